// File: doc/BRIEF.md
# Criticality-Aware Cluster Steering Unit

This unit sits at the dispatch stage of a core that has two integer execution clusters. Each cluster has its own instruction queue. For every dispatched instruction it picks the cluster whose queue receives the instruction, or it signals a stall when neither queue can accept it. It uses the instruction's predicted-critical bit, where its source producers live, whether those producers are still executing, and how many free entries each queue has.

There are three steering policies. In the blind policy, criticality alone places critical instructions in a fixed critical cluster, and all other instructions are balanced by free space. The two register policies follow the producers of the source operands. When the operands come from both clusters, the criticality bit breaks the tie. The active-register policy counts only producers that have not yet completed. A full queue or a large occupancy gap overrides the register choice. The decision is registered: it appears one clock after the dispatch request.

Top module: `crit_steer_unit`

## Requirements
- R1: While reset is held and after its release, with no request, `steer_valid_o` and `stall_o` are both 0.
- R2: A request seen while both free counts are 0 gives `stall_o`=1 and `steer_valid_o`=0 one cycle later.
- R3: In blind policy (`mode_i` 0, and also 3), a critical request goes to cluster `CRIT_CLUSTER` (default 0) whenever that queue's free count is nonzero.
- R4: A request that has no counted producers goes to the cluster with the larger free count, or to cluster 0 when the counts are equal. This applies to every non-critical blind request and to every register-policy request without producers.
- R5: In register policy (`mode_i` 1), a request whose valid sources all come from one cluster goes to that cluster. The cluster is given by `src_cluster_i` bit i for source i, and a source counts when its `src_vld_i` bit is 1.
- R6: In a register policy, when valid sources come from both clusters, a critical request goes to `CRIT_CLUSTER`. A non-critical request follows R4's free-count rule.
- R7: In active-register policy (`mode_i` 2), a source counts only when its `src_active_i` bit is also 1.
- R8: In a register policy, if the chosen queue has 0 free entries and the other does not, the request goes to the other cluster.
- R9: In a register policy, if the other queue's free count exceeds the chosen one's by more than `IMB_THRESH` (default 8), the request goes to the other cluster. A gap of exactly `IMB_THRESH` does not move it.
- R10: Every decision appears exactly one clock after its request, and `steer_valid_o` and `stall_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request this cycle |
| crit_i | input | 1 | Predicted-critical bit |
| mode_i | input | 2 | Policy: 0 blind, 1 register, 2 active-register, 3 blind |
| src_vld_i | input | NSRC | Source i has a tracked producer |
| src_cluster_i | input | NSRC | Cluster of source i's producer |
| src_active_i | input | NSRC | Source i's producer has not completed |
| free0_i | input | CNT_W | Free entries in queue 0 |
| free1_i | input | CNT_W | Free entries in queue 1 |
| steer_valid_o | output | 1 | Registered decision is a placement |
| steer_cluster_o | output | 1 | Target cluster |
| stall_o | output | 1 | Neither queue can accept |

## Verification
A wrong producer tally or a wrong override flag shows up as a wrong `steer_cluster_o` on the cycle right after the request. A stale tie-break or balance comparison shows up the same way. None of this state persists across requests, so every fault is visible within one clock of the stimulus that exposes it. A mis-set full flag shows up as a missing or spurious `stall_o` in that same cycle. The stimulus concentrates on producer splits, near-threshold occupancy gaps and full queues, because those decide between the competing rules.

// File: rtl/crit_steer_pkg.sv
package crit_steer_pkg;
  typedef enum logic [1:0] {
    POL_BLIND  = 2'd0,
    POL_REG    = 2'd1,
    POL_ACTREG = 2'd2,
    POL_ALT    = 2'd3
  } steer_pol_e;

  typedef struct packed {
    logic stall;
    logic cluster;
  } steer_dec_t;
endpackage

// File: rtl/crit_steer_operand_loc.sv
module crit_steer_operand_loc #(
  parameter int NSRC = 2
) (
  input  logic            active_only_i,
  input  logic [NSRC-1:0] src_vld_i,
  input  logic [NSRC-1:0] src_cluster_i,
  input  logic [NSRC-1:0] src_active_i,
  output logic            in_c0_o,
  output logic            in_c1_o
);
  logic [NSRC-1:0] cnt_src, hit0, hit1;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign cnt_src[i] = src_vld_i[i] & (~active_only_i | src_active_i[i]);
    assign hit0[i]    = cnt_src[i] & ~src_cluster_i[i];
    assign hit1[i]    = cnt_src[i] &  src_cluster_i[i];
  end

  assign in_c0_o = |hit0;
  assign in_c1_o = |hit1;
endmodule

// File: rtl/crit_steer_balance.sv
module crit_steer_balance #(
  parameter int CNT_W      = 6,
  parameter int IMB_THRESH = 8
) (
  input  logic [CNT_W-1:0] free0_i,
  input  logic [CNT_W-1:0] free1_i,
  output logic             full0_o,
  output logic             full1_o,
  output logic             roomier_o,   // cluster with more free entries, 0 on equal
  output logic             imbal_o      // gap exceeds threshold
);
  localparam int DW = CNT_W + 1;
  logic [DW-1:0] gap;

  assign full0_o   = (free0_i == '0);
  assign full1_o   = (free1_i == '0);
  assign roomier_o = (free1_i > free0_i);
  assign gap       = roomier_o ? ({1'b0, free1_i} - {1'b0, free0_i})
                               : ({1'b0, free0_i} - {1'b0, free1_i});
  assign imbal_o   = (gap > DW'(IMB_THRESH));
endmodule

// File: rtl/crit_steer_unit.sv
module crit_steer_unit
  import crit_steer_pkg::*;
#(
  parameter int   NSRC         = 2,
  parameter int   QDEPTH       = 32,
  parameter int   IMB_THRESH   = 8,
  parameter logic CRIT_CLUSTER = 1'b0,
  localparam int  CNT_W        = $clog2(QDEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disp_valid_i,
  input  logic             crit_i,
  input  logic [1:0]       mode_i,
  input  logic [NSRC-1:0]  src_vld_i,
  input  logic [NSRC-1:0]  src_cluster_i,
  input  logic [NSRC-1:0]  src_active_i,
  input  logic [CNT_W-1:0] free0_i,
  input  logic [CNT_W-1:0] free1_i,
  output logic             steer_valid_o,
  output logic             steer_cluster_o,
  output logic             stall_o
);
  steer_pol_e pol;
  logic       reg_pol, in_c0, in_c1;
  logic       full0, full1, roomier, imbal;
  logic       pref, pick, crit_room;
  steer_dec_t dec;

  assign pol     = steer_pol_e'(mode_i);
  assign reg_pol = (pol == POL_REG) || (pol == POL_ACTREG);

  crit_steer_operand_loc #(.NSRC(NSRC)) u_loc (
    .active_only_i (pol == POL_ACTREG),
    .src_vld_i     (src_vld_i),
    .src_cluster_i (src_cluster_i),
    .src_active_i  (src_active_i),
    .in_c0_o       (in_c0),
    .in_c1_o       (in_c1)
  );

  crit_steer_balance #(.CNT_W(CNT_W), .IMB_THRESH(IMB_THRESH)) u_bal (
    .free0_i   (free0_i),
    .free1_i   (free1_i),
    .full0_o   (full0),
    .full1_o   (full1),
    .roomier_o (roomier),
    .imbal_o   (imbal)
  );

  assign crit_room = CRIT_CLUSTER ? ~full1 : ~full0;

  always_comb begin
    // operand-location preference
    if (in_c0 && !in_c1)      pref = 1'b0;
    else if (in_c1 && !in_c0) pref = 1'b1;
    else if (in_c0 && in_c1)  pref = crit_i ? CRIT_CLUSTER : roomier;
    else                      pref = roomier;

    if (!reg_pol) begin
      pick = (crit_i && crit_room) ? CRIT_CLUSTER : roomier;
    end else begin
      pick = pref;
      if (pref ? full1 : full0) pick = ~pref;
      else if (imbal && (pref != roomier)) pick = roomier;
    end

    dec.stall   = full0 & full1;
    dec.cluster = pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_valid_o   <= 1'b0;
      steer_cluster_o <= 1'b0;
      stall_o         <= 1'b0;
    end else begin
      steer_valid_o   <= disp_valid_i & ~dec.stall;
      stall_o         <= disp_valid_i &  dec.stall;
      steer_cluster_o <= dec.stall ? 1'b0 : dec.cluster;
    end
  end

  AST_STALL_BOTH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && free0_i == '0 && free1_i == '0 |=> stall_o && !steer_valid_o); // R2

  AST_BLIND_CRIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && !reg_pol && crit_i && (CRIT_CLUSTER ? free1_i != '0 : free0_i != '0)
    |=> steer_valid_o && steer_cluster_o == CRIT_CLUSTER); // R3

  AST_AVOID_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && (free0_i == '0) != (free1_i == '0)
    |=> steer_valid_o && steer_cluster_o == $past(free0_i == '0)); // R8

  AST_IMBAL_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && reg_pol && free0_i != '0 && 32'(free1_i) > 32'(free0_i) + IMB_THRESH
    |=> steer_cluster_o); // R9

  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_valid_i |=> !steer_valid_o && !stall_o); // R10

  AST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(steer_valid_o && stall_o)); // R10
endmodule

// File: tb/crit_steer_unit_tb.sv
module crit_steer_unit_tb;
  localparam int   NSRC = 2;
  localparam int   QDEPTH = 32;
  localparam int   THR = 8;
  localparam logic CC = 1'b0;
  localparam int   CW = $clog2(QDEPTH + 1);

  logic clk_i = 0, rst_ni = 0;
  logic disp_valid_i = 0, crit_i = 0;
  logic [1:0] mode_i = 0;
  logic [NSRC-1:0] src_vld_i = 0, src_cluster_i = 0, src_active_i = 0;
  logic [CW-1:0] free0_i = 0, free1_i = 0;
  logic steer_valid_o, steer_cluster_o, stall_o;

  int n_chk = 0, n_bad = 0;
  string tag;

  always #5 clk_i = ~clk_i;

  crit_steer_unit #(.NSRC(NSRC), .QDEPTH(QDEPTH), .IMB_THRESH(THR), .CRIT_CLUSTER(CC)) u_dut (
    .clk_i, .rst_ni, .disp_valid_i, .crit_i, .mode_i, .src_vld_i, .src_cluster_i,
    .src_active_i, .free0_i, .free1_i, .steer_valid_o, .steer_cluster_o, .stall_o);

  // expected {valid, stall, cluster}; sets tag to the deciding rule
  function automatic logic [2:0] model(logic v, logic c, logic [1:0] m, logic [1:0] sv,
                                       logic [1:0] sc, logic [1:0] sa, int f0, int f1);
    logic more, p, h0, h1, rg;
    more = (f1 > f0);
    if (!v) begin tag = "R10"; return 3'b000; end
    if (f0 == 0 && f1 == 0) begin tag = "R2"; return 3'b010; end
    rg = (m == 2'd1 || m == 2'd2);
    if (!rg) begin
      if (c && (CC ? f1 : f0) != 0) begin tag = "R3"; return {2'b10, CC}; end
      tag = "R4"; return {2'b10, more};
    end
    h0 = 0; h1 = 0;
    for (int i = 0; i < 2; i++)
      if (sv[i] && (m == 2'd1 || sa[i])) begin
        if (sc[i]) h1 = 1; else h0 = 1;
      end
    if (h0 && !h1) begin p = 0; tag = (m == 2'd2) ? "R7" : "R5"; end
    else if (h1 && !h0) begin p = 1; tag = (m == 2'd2) ? "R7" : "R5"; end
    else if (h0 && h1) begin p = c ? CC : more; tag = "R6"; end
    else begin p = more; tag = "R4"; end
    if ((p ? f1 : f0) == 0) begin p = ~p; tag = "R8"; end
    else if ((p ? f0 - f1 : f1 - f0) > THR) begin p = ~p; tag = "R9"; end
    return {2'b10, p};
  endfunction

  task automatic apply(logic v, logic c, logic [1:0] m, logic [1:0] sv, logic [1:0] sc,
                       logic [1:0] sa, int f0, int f1);
    logic [2:0] e;
    disp_valid_i = v; crit_i = c; mode_i = m; src_vld_i = sv; src_cluster_i = sc;
    src_active_i = sa; free0_i = CW'(f0); free1_i = CW'(f1);
    e = model(v, c, m, sv, sc, sa, f0, f1);
    @(posedge clk_i); @(negedge clk_i);
    n_chk++;
    if ({steer_valid_o, stall_o, e[2] ? steer_cluster_o : 1'b0} !== e) begin
      n_bad++;
      $display("FAIL %s: got v=%b s=%b c=%b exp v=%b s=%b c=%b", tag,
               steer_valid_o, stall_o, steer_cluster_o, e[2], e[1], e[0]);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    n_chk++;
    if (steer_valid_o !== 0 || stall_o !== 0) begin
      n_bad++; $display("FAIL R1: got v=%b s=%b exp 0 0", steer_valid_o, stall_o);
    end
    rst_ni = 1;
    @(negedge clk_i);
    n_chk++;
    if (steer_valid_o !== 0 || stall_o !== 0) begin
      n_bad++; $display("FAIL R1: got v=%b s=%b exp 0 0", steer_valid_o, stall_o);
    end
    // directed corners
    apply(1, 1, 0, 0, 0, 0, 0, 0);      // R2 stall
    apply(1, 1, 0, 0, 0, 0, 3, 20);     // R3 crit to CC despite imbalance
    apply(1, 1, 3, 0, 0, 0, 3, 20);     // R3 mode 3 as blind
    apply(1, 1, 0, 0, 0, 0, 0, 5);      // R3 CC full -> R4 fallback
    apply(1, 0, 0, 0, 0, 0, 7, 7);      // R4 equal -> 0
    apply(1, 0, 0, 0, 0, 0, 6, 7);      // R4
    apply(1, 0, 1, 2'b11, 2'b11, 0, 10, 9); // R5 both in 1
    apply(1, 0, 1, 2'b01, 2'b00, 0, 9, 10); // R5 one in 0
    apply(1, 1, 1, 2'b11, 2'b10, 0, 5, 9);  // R6 crit split -> CC
    apply(1, 0, 1, 2'b11, 2'b10, 0, 5, 9);  // R6 noncrit split -> roomier
    apply(1, 0, 2, 2'b11, 2'b10, 2'b10, 9, 5); // R7 only active in 1
    apply(1, 0, 2, 2'b11, 2'b10, 2'b00, 9, 5); // R7 none active -> R4
    apply(1, 0, 1, 2'b01, 2'b01, 0, 9, 0);  // R8 target full
    apply(1, 0, 1, 2'b01, 2'b00, 0, 2, 10); // R9 exactly THR -> stays
    apply(1, 0, 1, 2'b01, 2'b00, 0, 2, 11); // R9 exceeds -> moves
    apply(0, 1, 1, 2'b01, 2'b00, 0, 0, 0);  // R10 idle
    for (int k = 0; k < 3000; k++) begin
      int f0, f1;
      f0 = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(0, QDEPTH);
      f1 = ($urandom_range(0, 5) == 0) ? 0 :
           ($urandom_range(0, 1) ? f0 + $urandom_range(0, 12) - 6 : $urandom_range(0, QDEPTH));
      if (f1 < 0) f1 = 0;
      if (f1 > QDEPTH) f1 = QDEPTH;
      apply($urandom_range(0, 7) != 0, 1'($urandom), 2'($urandom), 2'($urandom),
            2'($urandom), 2'($urandom), f0, f1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule